// File: doc/BRIEF.md
# Parallel Port Peripheral Slave with EPP and Nibble Read

This block is the peripheral side of a legacy printer-port link in a scanner controller. A host drives an 8-bit data bus and three active-low control strobes: a direction line (low for host writes, high for host reads), an address strobe and a data strobe. The block answers with a single wait/acknowledge line. All host strobes are asynchronous and are brought into the block's clock domain through two-flop synchronizers before any decision is taken.

An address cycle loads an internal register pointer. Each later data cycle reads or writes the core register the pointer selects, through a simple strobe-and-data register port. One pointer value is reserved for a streaming port with valid/ready flow control. Stream accesses may stall the host for as long as the stream is not ready. A mode input chooses full-byte reads on the data bus, or nibble reads. In nibble reads the byte comes back on four status lines, upper half first and lower half after the host releases the data strobe.

Top module: `hostport_slave`

## Requirements
- R1: After reset `hs_busy`, `hd_oe`, `reg_we`, `reg_re`, `strm_rd_take` and `strm_wr_valid` are 0, `hs_stat` is 0 and `reg_addr` (the pointer) is 0.
- R2: With `hs_dir` low, `hs_sel_n` low starts an address cycle. The host byte is loaded into the pointer (visible on `reg_addr`), `hs_busy` rises, and `hs_busy` falls only after `hs_sel_n` returns high. If `hs_sel_n` and `hs_dat_n` fall together, the address cycle wins and no register write is issued.
- R3: A data write (`hs_dat_n` low, `hs_dir` low) to a non-stream pointer issues exactly one `reg_we` pulse. The pulse carries `reg_addr` equal to the pointer and `reg_wdata` equal to the host byte, in the same cycle `hs_busy` rises. `hs_busy` falls after `hs_dat_n` returns high, and the pointer is unchanged.
- R4: A data read (`hs_dat_n` low, `hs_dir` high, `nib_mode` 0) to a non-stream pointer pulses `reg_re`. `reg_rdata` is taken in the cycle `reg_re` is high. `hd_out` then shows that byte with `hd_oe` high for at least one cycle before `hs_busy` rises.
- R5: At the end of a read, `hs_busy` and `hd_oe` go low at the third rising clock edge after `hs_dat_n` returns high, and not earlier.
- R6: With `nib_mode` 1, `hd_oe` stays 0 during reads. `hs_stat` shows data bits [7:4] before `hs_busy` rises. It shows bits [3:0] from the edge where `hs_busy` falls and holds them until the next nibble read.
- R7: The pointer value `STRM_ADDR` (default 8'hF0) selects the stream. A write there raises `strm_wr_valid` with `strm_wr_data` equal to the host byte and holds both until `strm_wr_ready` is high at a clock edge. `hs_busy` rises only at that transfer edge.
- R8: A read at `STRM_ADDR` waits for `strm_rd_valid`, returns `strm_rd_data` on the host bus, and pulses `strm_rd_take` for one cycle in the cycle `hs_busy` rises. The pointer does not change across stream accesses.
- R9: If the data strobe is released before `hs_busy` has risen, the cycle is abandoned. `hs_busy` stays low, and no stream transfer and no `strm_rd_take` occur.
- R10: At most one of `reg_we`, `reg_re` and `strm_rd_take` is high in any cycle, and `reg_we` is only high in the cycle in which `hs_busy` has just risen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| nib_mode | input | 1 | 1: reads return nibbles on `hs_stat`; 0: full-byte reads on `hd_out` |
| hs_dir | input | 1 | Host direction: 0 write, 1 read (asynchronous) |
| hs_sel_n | input | 1 | Host address strobe, active low (asynchronous) |
| hs_dat_n | input | 1 | Host data strobe, active low (asynchronous) |
| hs_busy | output | 1 | Wait/acknowledge line to the host |
| hd_in | input | 8 | Host data bus, input side |
| hd_out | output | 8 | Host data bus, output side |
| hd_oe | output | 1 | Drive enable for `hd_out` |
| hs_stat | output | 4 | Status lines carrying nibble read data |
| reg_addr | output | 8 | Register pointer toward the core |
| reg_wdata | output | 8 | Register write data |
| reg_we | output | 1 | Register write pulse |
| reg_re | output | 1 | Register read pulse |
| reg_rdata | input | 8 | Register read data, valid while `reg_re` is high |
| strm_wr_valid | output | 1 | Stream write data valid |
| strm_wr_ready | input | 1 | Stream sink ready |
| strm_wr_data | output | 8 | Stream write byte |
| strm_rd_valid | input | 1 | Stream source has a byte |
| strm_rd_data | input | 8 | Stream source byte, held while valid until taken |
| strm_rd_take | output | 1 | Stream source byte consumed |

## Verification
The assertions assume a well-behaved host and core. The host keeps `hs_dir` and `hd_in` steady for the whole of a cycle, and `nib_mode` is changed only between cycles. A stream source keeps `strm_rd_data` stable while `strm_rd_valid` is high. The register core answers `reg_rdata` combinationally from `reg_addr`. The directed stimulus changes every host input at the falling clock edge and only ever releases a strobe after deciding to. It flips the mode only while `hs_busy` is low and idle, and it models the core as a byte array read through `reg_addr`.

// File: rtl/hp_pkg.sv
// Shared types for the parallel port slave.
// Assumes: one handshake state machine per port instance.
package hp_pkg;

    // Handshake states of one host cycle.
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,  // waiting for a strobe
        ST_ADDR   = 3'd1,  // address loaded, acknowledging
        ST_WACK   = 3'd2,  // write done, acknowledging
        ST_WPUSH  = 3'd3,  // stream write waiting for sink
        ST_RFETCH = 3'd4,  // register read issued
        ST_RWAIT  = 3'd5,  // stream read waiting for source
        ST_RSHOW  = 3'd6,  // data presented, acknowledge next
        ST_RACK   = 3'd7   // read acknowledged, waiting for release
    } hp_state_t;

endpackage

// File: rtl/hp_sync.sv
// Multi-stage synchronizer for a group of asynchronous single-bit inputs.
// Assumes: each bit is independent (no multi-bit coherence required);
// reset value chosen to match the idle level of the inputs.
module hp_sync #(
    parameter int W       = 3,
    parameter int STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);

    logic [W-1:0] stage_q [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // First flop: capture the asynchronous inputs.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= RST_VAL;
                    else        stage_q[0] <= d_async;
                end
            end else begin : g_next
                // Later flops: let metastability settle.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[g] <= RST_VAL;
                    else        stage_q[g] <= stage_q[g-1];
                end
            end
        end
    endgenerate

    assign q_sync = stage_q[STAGES-1];

endmodule

// File: rtl/hp_cycle_fsm.sv
// Host cycle handshake state machine.
// Decodes address, write and read cycles from synchronized strobe levels,
// drives the acknowledge line and issues the core-side actions.
// Assumes: strobes are active-high here (already inverted and synchronized);
// the direction level is stable for the whole cycle.
module hp_cycle_fsm
    import hp_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      dir_rd,     // synchronized direction, 1 = read
    input  logic      sel_act,    // synchronized address strobe active
    input  logic      dat_act,    // synchronized data strobe active
    input  logic      strm_hit,   // pointer selects the stream
    input  logic      wr_ready,   // stream sink ready
    input  logic      rd_valid,   // stream source valid
    output logic      busy,
    output logic      core_we,
    output logic      core_re,
    output logic      ld_addr,
    output logic      ld_wdata,
    output logic      ld_rdata,
    output logic      rd_done,
    output logic      rd_drop,
    output logic      rd_take,
    output logic      wr_valid
);

    hp_state_t st_q, st_d;
    logic      busy_d, we_d, re_d;

    // Next-state and action decode for one host cycle.
    always_comb begin
        st_d     = st_q;
        busy_d   = busy;
        we_d     = 1'b0;
        re_d     = 1'b0;
        ld_addr  = 1'b0;
        ld_wdata = 1'b0;
        ld_rdata = 1'b0;
        rd_done  = 1'b0;
        rd_drop  = 1'b0;
        rd_take  = 1'b0;
        case (st_q)
            ST_IDLE: begin
                if (sel_act && !dir_rd) begin
                    ld_addr = 1'b1;
                    busy_d  = 1'b1;
                    st_d    = ST_ADDR;
                end else if (dat_act && !dir_rd) begin
                    ld_wdata = 1'b1;
                    if (strm_hit) begin
                        st_d = ST_WPUSH;
                    end else begin
                        we_d   = 1'b1;
                        busy_d = 1'b1;
                        st_d   = ST_WACK;
                    end
                end else if (dat_act && dir_rd) begin
                    if (strm_hit) begin
                        st_d = ST_RWAIT;
                    end else begin
                        re_d = 1'b1;
                        st_d = ST_RFETCH;
                    end
                end
            end
            ST_ADDR: begin
                if (!sel_act) begin
                    busy_d = 1'b0;
                    st_d   = ST_IDLE;
                end
            end
            ST_WACK: begin
                if (!dat_act) begin
                    busy_d = 1'b0;
                    st_d   = ST_IDLE;
                end
            end
            ST_WPUSH: begin
                if (wr_ready) begin
                    busy_d = 1'b1;
                    st_d   = ST_WACK;
                end else if (!dat_act) begin
                    st_d = ST_IDLE;
                end
            end
            ST_RFETCH: begin
                if (!dat_act) begin
                    st_d = ST_IDLE;
                end else begin
                    ld_rdata = 1'b1;
                    st_d     = ST_RSHOW;
                end
            end
            ST_RWAIT: begin
                if (!dat_act) begin
                    st_d = ST_IDLE;
                end else if (rd_valid) begin
                    ld_rdata = 1'b1;
                    st_d     = ST_RSHOW;
                end
            end
            ST_RSHOW: begin
                if (!dat_act) begin
                    rd_drop = 1'b1;
                    st_d    = ST_IDLE;
                end else begin
                    busy_d  = 1'b1;
                    rd_take = strm_hit;
                    st_d    = ST_RACK;
                end
            end
            ST_RACK: begin
                if (!dat_act) begin
                    busy_d  = 1'b0;
                    rd_done = 1'b1;
                    st_d    = ST_IDLE;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // State, acknowledge and core strobe registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            busy    <= 1'b0;
            core_we <= 1'b0;
            core_re <= 1'b0;
        end else begin
            st_q    <= st_d;
            busy    <= busy_d;
            core_we <= we_d;
            core_re <= re_d;
        end
    end

    assign wr_valid = (st_q == ST_WPUSH);

endmodule

// File: rtl/hp_data_path.sv
// Data side of the port: register pointer, write byte, read byte latch,
// host bus drive enable and nibble status lines.
// Assumes: load pulses come from hp_cycle_fsm and are mutually exclusive.
module hp_data_path #(
    parameter int          DW        = 8,
    parameter logic [DW-1:0] STRM_ADDR = 8'hF0,
    localparam int         NW        = DW / 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          nib_mode,
    input  logic [DW-1:0] hd_in,
    input  logic [DW-1:0] reg_rdata,
    input  logic [DW-1:0] strm_rd_data,
    input  logic          ld_addr,
    input  logic          ld_wdata,
    input  logic          ld_rdata,
    input  logic          rd_done,
    input  logic          rd_drop,
    output logic          strm_hit,
    output logic [DW-1:0] ptr,
    output logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          oe,
    output logic [NW-1:0] stat
);

    logic [DW-1:0] rd_src;

    // Pick the read source the pointer selects.
    assign rd_src   = strm_hit ? strm_rd_data : reg_rdata;
    assign strm_hit = (ptr == STRM_ADDR);

    // Pointer and write byte capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr   <= '0;
            wdata <= '0;
        end else begin
            if (ld_addr)  ptr   <= hd_in;
            if (ld_wdata) wdata <= hd_in;
        end
    end

    // Read byte latch and byte-mode bus enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
            oe    <= 1'b0;
        end else begin
            if (ld_rdata) begin
                rdata <= rd_src;
                oe    <= !nib_mode;
            end else if (rd_done || rd_drop) begin
                oe    <= 1'b0;
            end
        end
    end

    // Nibble status lines: upper half first, lower half after release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat <= '0;
        end else if (nib_mode) begin
            if (ld_rdata)     stat <= rd_src[DW-1:NW];
            else if (rd_done) stat <= rdata[NW-1:0];
        end
    end

endmodule

// File: rtl/hostport_slave.sv
// Top of the parallel port peripheral slave.
// Synchronizes the host strobes, runs the handshake machine and the data
// path, and exposes a register port and a valid/ready stream port.
// Assumes: host data and direction are stable while a strobe is active.
module hostport_slave #(
    parameter int            DW          = 8,
    parameter int            SYNC_STAGES = 2,
    parameter logic [DW-1:0] STRM_ADDR   = 8'hF0,
    localparam int           NW          = DW / 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          nib_mode,
    input  logic          hs_dir,
    input  logic          hs_sel_n,
    input  logic          hs_dat_n,
    output logic          hs_busy,
    input  logic [DW-1:0] hd_in,
    output logic [DW-1:0] hd_out,
    output logic          hd_oe,
    output logic [NW-1:0] hs_stat,
    output logic [DW-1:0] reg_addr,
    output logic [DW-1:0] reg_wdata,
    output logic          reg_we,
    output logic          reg_re,
    input  logic [DW-1:0] reg_rdata,
    output logic          strm_wr_valid,
    input  logic          strm_wr_ready,
    output logic [DW-1:0] strm_wr_data,
    input  logic          strm_rd_valid,
    input  logic [DW-1:0] strm_rd_data,
    output logic          strm_rd_take
);

    logic [2:0] sync_q;
    logic       dir_rd, sel_act, dat_act, strm_hit;
    logic       ld_addr, ld_wdata, ld_rdata, rd_done, rd_drop;
    logic [DW-1:0] wdata;

    // Strobe synchronizers; idle levels are direction 0, strobes high.
    hp_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({hs_sel_n, hs_dat_n, hs_dir}),
        .q_sync  (sync_q)
    );

    assign sel_act = !sync_q[2];
    assign dat_act = !sync_q[1];
    assign dir_rd  =  sync_q[0];

    hp_cycle_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .dir_rd   (dir_rd),
        .sel_act  (sel_act),
        .dat_act  (dat_act),
        .strm_hit (strm_hit),
        .wr_ready (strm_wr_ready),
        .rd_valid (strm_rd_valid),
        .busy     (hs_busy),
        .core_we  (reg_we),
        .core_re  (reg_re),
        .ld_addr  (ld_addr),
        .ld_wdata (ld_wdata),
        .ld_rdata (ld_rdata),
        .rd_done  (rd_done),
        .rd_drop  (rd_drop),
        .rd_take  (strm_rd_take),
        .wr_valid (strm_wr_valid)
    );

    hp_data_path #(.DW(DW), .STRM_ADDR(STRM_ADDR)) u_dp (
        .clk          (clk),
        .rst_n        (rst_n),
        .nib_mode     (nib_mode),
        .hd_in        (hd_in),
        .reg_rdata    (reg_rdata),
        .strm_rd_data (strm_rd_data),
        .ld_addr      (ld_addr),
        .ld_wdata     (ld_wdata),
        .ld_rdata     (ld_rdata),
        .rd_done      (rd_done),
        .rd_drop      (rd_drop),
        .strm_hit     (strm_hit),
        .ptr          (reg_addr),
        .wdata        (wdata),
        .rdata        (hd_out),
        .oe           (hd_oe),
        .stat         (hs_stat)
    );

    assign reg_wdata    = wdata;
    assign strm_wr_data = wdata;

endmodule

// File: rtl/hp_checker.sv
// Protocol checker for hostport_slave, attached by bind.
// Assumes: host keeps nib_mode constant during a cycle and the stream source
// holds its byte while valid.
module hp_checker #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          nib_mode,
    input logic          hs_busy,
    input logic [DW-1:0] hd_out,
    input logic          hd_oe,
    input logic          reg_we,
    input logic          reg_re,
    input logic          strm_wr_valid,
    input logic          strm_wr_ready,
    input logic [DW-1:0] strm_wr_data,
    input logic          strm_rd_valid,
    input logic          strm_rd_take
);

    // R10: one core action per cycle.
    a_r10_one_core_op: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({reg_we, reg_re, strm_rd_take}));

    // R3 / R10: a register write coincides with the acknowledge rising.
    a_r3_we_on_busy_rise: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> (hs_busy && !$past(hs_busy)));

    // R4: read data is on the bus a cycle before the acknowledge.
    a_r4_data_before_busy: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(hs_busy) && hd_oe) |-> ($past(hd_oe) && $stable(hd_out)));

    // R5: the bus is released together with the acknowledge.
    a_r5_oe_with_busy_fall: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(hs_busy) && $past(hd_oe)) |-> !hd_oe);

    // R6: nibble mode never drives the data bus.
    a_r6_no_drive_nibble: assert property (@(posedge clk) disable iff (!rst_n)
        nib_mode |-> !hd_oe);

    // R7: stream write byte held while waiting for the sink.
    a_r7_hold_wr_data: assert property (@(posedge clk) disable iff (!rst_n)
        (strm_wr_valid && $past(strm_wr_valid)) |-> $stable(strm_wr_data));

    // R8: a stream byte is only taken when offered.
    a_r8_take_when_valid: assert property (@(posedge clk) disable iff (!rst_n)
        strm_rd_take |-> strm_rd_valid);

endmodule

bind hostport_slave hp_checker #(.DW(DW)) u_chk (.*);

// File: tb/tb_hostport_slave.sv
`timescale 1ns/1ps
module tb_hostport_slave;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       nib_mode = 1'b0;
    logic       hs_dir = 1'b0, hs_sel_n = 1'b1, hs_dat_n = 1'b1;
    logic       hs_busy;
    logic [7:0] hd_in = 8'h00, hd_out;
    logic       hd_oe;
    logic [3:0] hs_stat;
    logic [7:0] reg_addr, reg_wdata, reg_rdata;
    logic       reg_we, reg_re;
    logic       strm_wr_valid, strm_wr_ready = 1'b0;
    logic [7:0] strm_wr_data;
    logic       strm_rd_valid = 1'b0;
    logic [7:0] strm_rd_data = 8'h00;
    logic       strm_rd_take;

    int n_tests = 0, n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    hostport_slave dut (.*);

    // Core model: byte array written by reg_we, read combinationally.
    logic [7:0] mem [256];
    int we_cnt = 0, re_cnt = 0, xfer_cnt = 0, take_cnt = 0, rise_cnt = 0, oe_cnt = 0;
    logic [7:0] last_xfer = 8'h00;
    logic busy_prev = 1'b0;
    assign reg_rdata = mem[reg_addr];

    always @(posedge clk) begin
        if (reg_we) begin mem[reg_addr] <= reg_wdata; we_cnt++; end
        if (reg_re) re_cnt++;
        if (strm_wr_valid && strm_wr_ready) begin xfer_cnt++; last_xfer <= strm_wr_data; end
        if (strm_rd_take) take_cnt++;
        if (hs_busy && !busy_prev) rise_cnt++;
        if (hd_oe) oe_cnt++;
        busy_prev <= hs_busy;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_busy(input logic lvl, input string req);
        bit hit = 1'b0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (hs_busy == lvl) begin hit = 1'b1; break; end
        end
        chk(hit, req, hs_busy, lvl);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic host_addr(input logic [7:0] a);
        @(negedge clk); hs_dir = 1'b0; hd_in = a; hs_sel_n = 1'b0;
        wait_busy(1'b1, "R2 busy rise on address");
        hs_sel_n = 1'b1;
        wait_busy(1'b0, "R2 busy fall on address");
    endtask

    task automatic host_write(input logic [7:0] d);
        @(negedge clk); hs_dir = 1'b0; hd_in = d; hs_dat_n = 1'b0;
        wait_busy(1'b1, "R3 busy rise on write");
        hs_dat_n = 1'b1;
        wait_busy(1'b0, "R3 busy fall on write");
    endtask

    // Byte or nibble read; checks the 3-edge acknowledge fall (R5).
    task automatic host_read(output logic [7:0] d, output logic oe_at,
                             output logic [3:0] hi, output logic [3:0] lo);
        @(negedge clk); hs_dir = 1'b1; hs_dat_n = 1'b0;
        wait_busy(1'b1, "R4 busy rise on read");
        d = hd_out; oe_at = hd_oe; hi = hs_stat;
        hs_dat_n = 1'b1;
        idle(2);
        chk(hs_busy == 1'b1, "R5 busy still high two edges after release", hs_busy, 1);
        idle(1);
        chk(hs_busy == 1'b0, "R5 busy low at third edge", hs_busy, 0);
        chk(hd_oe == 1'b0, "R5 bus released with busy", hd_oe, 0);
        lo = hs_stat;
        hs_dir = 1'b0;
    endtask

    task automatic t_reset;
        chk(!hs_busy && !hd_oe && !reg_we && !reg_re && !strm_rd_take && !strm_wr_valid,
            "R1 control outputs idle after reset", {hs_busy, hd_oe, reg_we, reg_re}, 0);
        chk(hs_stat == 4'h0 && reg_addr == 8'h00, "R1 status and pointer zero",
            {hs_stat, reg_addr}, 0);
    endtask

    task automatic t_addr;
        host_addr(8'h12);
        chk(reg_addr == 8'h12, "R2 pointer loaded", reg_addr, 8'h12);
    endtask

    task automatic t_write;
        int w0 = we_cnt;
        host_write(8'hA5);
        idle(1);
        chk(mem[8'h12] == 8'hA5, "R3 register written", mem[8'h12], 8'hA5);
        chk(we_cnt - w0 == 1, "R3 R10 one write pulse", we_cnt - w0, 1);
        chk(reg_addr == 8'h12, "R3 pointer unchanged", reg_addr, 8'h12);
    endtask

    task automatic t_read_byte;
        logic [7:0] d; logic oe_at; logic [3:0] hi, lo;
        int r0;
        host_addr(8'h20);
        host_write(8'h3C);
        r0 = re_cnt;
        host_read(d, oe_at, hi, lo);
        chk(d == 8'h3C, "R4 read byte on bus", d, 8'h3C);
        chk(oe_at == 1'b1, "R4 bus driven at busy rise", oe_at, 1);
        chk(re_cnt - r0 == 1, "R4 one read pulse", re_cnt - r0, 1);
    endtask

    task automatic t_read_nibble;
        logic [7:0] d; logic oe_at; logic [3:0] hi, lo;
        int o0;
        nib_mode = 1'b1;
        o0 = oe_cnt;
        host_read(d, oe_at, hi, lo);
        chk(hi == 4'h3, "R6 upper nibble first", hi, 4'h3);
        chk(lo == 4'hC, "R6 lower nibble after release", lo, 4'hC);
        chk(oe_cnt == o0, "R6 data bus never driven", oe_cnt - o0, 0);
        idle(4);
        chk(hs_stat == 4'hC, "R6 lower nibble held", hs_stat, 4'hC);
        nib_mode = 1'b0;
    endtask

    task automatic t_priority;
        int w0 = we_cnt;
        @(negedge clk); hs_dir = 1'b0; hd_in = 8'h44; hs_sel_n = 1'b0; hs_dat_n = 1'b0;
        wait_busy(1'b1, "R2 busy rise with both strobes");
        hs_sel_n = 1'b1; hs_dat_n = 1'b1;
        wait_busy(1'b0, "R2 busy fall with both strobes");
        idle(4);
        chk(reg_addr == 8'h44, "R2 address wins", reg_addr, 8'h44);
        chk(we_cnt == w0, "R2 no write when both strobes", we_cnt - w0, 0);
    endtask

    task automatic t_stream_write;
        int x0;
        host_addr(8'hF0);
        x0 = xfer_cnt;
        strm_wr_ready = 1'b0;
        @(negedge clk); hs_dir = 1'b0; hd_in = 8'h77; hs_dat_n = 1'b0;
        idle(10);
        chk(hs_busy == 1'b0, "R7 busy held low while sink stalls", hs_busy, 0);
        chk(strm_wr_valid && strm_wr_data == 8'h77, "R7 byte offered",
            {strm_wr_valid, strm_wr_data}, {1'b1, 8'h77});
        strm_wr_ready = 1'b1;
        wait_busy(1'b1, "R7 busy rise after transfer");
        strm_wr_ready = 1'b0;
        chk(xfer_cnt - x0 == 1 && last_xfer == 8'h77, "R7 one transfer of host byte",
            last_xfer, 8'h77);
        hs_dat_n = 1'b1;
        wait_busy(1'b0, "R7 busy fall");
    endtask

    task automatic t_stream_read;
        logic [7:0] d; logic oe_at; logic [3:0] hi, lo;
        int t0 = take_cnt;
        strm_rd_valid = 1'b0;
        @(negedge clk); hs_dir = 1'b1; hs_dat_n = 1'b0;
        idle(10);
        chk(hs_busy == 1'b0 && take_cnt == t0, "R8 waits for source", hs_busy, 0);
        strm_rd_data = 8'h5A; strm_rd_valid = 1'b1;
        wait_busy(1'b1, "R8 busy rise on stream read");
        d = hd_out;
        chk(d == 8'h5A, "R8 stream byte on bus", d, 8'h5A);
        chk(take_cnt - t0 == 1, "R8 one take", take_cnt - t0, 1);
        hs_dat_n = 1'b1;
        strm_rd_valid = 1'b0;
        wait_busy(1'b0, "R8 busy fall");
        hs_dir = 1'b0;
        chk(reg_addr == 8'hF0, "R8 pointer unchanged", reg_addr, 8'hF0);
        oe_at = 1'b0; hi = 4'h0; lo = 4'h0;
    endtask

    task automatic t_abort;
        int x0 = xfer_cnt, t0 = take_cnt, b0 = rise_cnt;
        strm_wr_ready = 1'b0;
        @(negedge clk); hs_dir = 1'b0; hd_in = 8'h99; hs_dat_n = 1'b0;
        idle(8);
        hs_dat_n = 1'b1;
        idle(8);
        chk(rise_cnt == b0 && xfer_cnt == x0, "R9 aborted write, no busy no transfer",
            rise_cnt - b0, 0);
        chk(strm_wr_valid == 1'b0, "R9 offer withdrawn", strm_wr_valid, 0);
        strm_rd_valid = 1'b0;
        @(negedge clk); hs_dir = 1'b1; hs_dat_n = 1'b0;
        idle(8);
        hs_dat_n = 1'b1;
        idle(8);
        hs_dir = 1'b0;
        chk(rise_cnt == b0 && take_cnt == t0, "R9 aborted read, no busy no take",
            take_cnt - t0, 0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        idle(5);
        rst_n = 1'b1;
        idle(1);
        t_reset();
        t_addr();
        t_write();
        t_read_byte();
        t_read_nibble();
        t_priority();
        t_stream_write();
        t_stream_read();
        t_abort();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule